// File: doc/BRIEF.md
# Minterm Command Sequencer

This block drives a bit-serial associative array so that the array computes one Boolean function per word. The function is given as a sum of products. Each product term is a ternary pattern over the 42 match bits, made of a value vector and a care mask. Software loads the terms into a small local store. It then starts a run, giving a term count, a round key and a target column.

The sequencer first clears an accumulator register in every word. For each term it issues a masked match and then a calculate step that ORs the match flag into the accumulator. The round key is folded into each pattern as the command is built, so the stored terms never change between rounds. After the last term, the accumulator is shifted into the neighbouring word. There it is XORed with the bit already held in the target column, and the result is written back to that column.

Each command is a single-cycle strobe. The sequencer waits for the array's completion pulse before it issues the next command. A counter reports the number of array cycles the run used.

Top module: `minterm_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o` and `finish_o` are 0 and `cycles_o` is 0.
- R2: A load strobe writes the value and care vectors into term slot `ld_addr_i` while the block is idle. A load strobe while busy has no effect on any term.
- R3: The first command of a run is a CALC (op code 1) to register R1 (register code 1) with truth table 8'h00, which clears the accumulator. In a truth table, bit i is the result for the register tuple i = {R3,R2,R1}. Fields that a command does not use are zero.
- R4: For each term slot k, taken in order from 0 to count-1, two commands are issued. The first is a MATCH (op code 0) to R2 (code 2) with care equal to the stored care and value equal to (stored value XOR key) AND care. The second is a CALC to R1 with truth table 8'hEE (R1 OR R2).
- R5: After the terms, four commands are issued in this order:
  - a SHIFT (op code 2) of R1;
  - a MATCH to R2 whose value and care both have only bit `col` set;
  - a CALC to R1 with truth table 8'h66 (R1 XOR R2);
  - a WRITECOLUMN (op code 3) from R1 with column `col`.
- R6: `cmd_valid_o` is high for exactly one cycle per command. The next command is issued in the cycle after the completion pulse is sampled. A completion pulse while idle has no effect.
- R7: `finish_o` pulses for one cycle, in the cycle after the final WRITECOLUMN completes. At that point `busy_o` is already 0.
- R8: `cycles_o` is cleared at start and grows by one in every busy cycle. The issue cycle and the completion cycle of each command both count. With MATCH costing 4 cycles and the other commands costing 2, a run of n terms reports 6n+12.
- R9: A run with count 0 issues the clear and then goes directly to the four-command XOR step.
- R10: A start strobe while busy is ignored. The current run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_en_i | input | 1 | Term store write strobe |
| ld_addr_i | input | 6 | Term slot to write |
| ld_value_i | input | 42 | Term value vector |
| ld_care_i | input | 42 | Term care mask (1 = compared) |
| start_i | input | 1 | Start a run |
| count_i | input | 7 | Number of terms (0..64) |
| key_i | input | 42 | Round key folded into patterns |
| col_i | input | 6 | Target column of the result |
| ack_i | input | 1 | Array completion pulse |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_op_o | output | 2 | Command op code |
| cmd_reg_o | output | 2 | Destination or source register |
| cmd_fn_o | output | 8 | CALC truth table |
| cmd_value_o | output | 42 | MATCH value |
| cmd_care_o | output | 42 | MATCH care mask |
| cmd_col_o | output | 6 | WRITECOLUMN column |
| busy_o | output | 1 | Run in progress |
| finish_o | output | 1 | Run complete pulse |
| cycles_o | output | 16 | Array cycles used by the current or last run |

## Verification
The checker watches the handshake on every cycle:
- a command strobe lasts one cycle and appears only while busy;
- the finish pulse lasts one cycle and arrives only after busy has fallen;
- every MATCH pattern keeps its wildcard positions at zero;
- every CALC uses one of the three legal truth tables;
- the cycle counter starts at zero and steps by one in each busy cycle.

Only the bench scenarios can show the rest. These cover the exact order of commands, the key folding of each stored term, the target column, and the 6n+12 total for the chosen costs. They also cover the empty function, the full 64-term store, and loads and restarts that arrive mid-run and must be ignored.

// File: rtl/minterm_seq_pkg.sv
package minterm_seq_pkg;
  typedef enum logic [1:0] {
    OP_MATCH = 2'd0,
    OP_CALC  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_WRCOL = 2'd3
  } op_e;

  localparam logic [1:0] REG_R1 = 2'd1;
  localparam logic [1:0] REG_R2 = 2'd2;

  // truth table bit i = f({R3,R2,R1} == i)
  localparam logic [7:0] FN_ZERO = 8'h00;
  localparam logic [7:0] FN_OR12 = 8'hEE;
  localparam logic [7:0] FN_XOR12 = 8'h66;

  typedef enum logic [2:0] {
    PH_CLR, PH_TERM, PH_ACC, PH_SHIFT, PH_RDCOL, PH_XOR, PH_WRCOL
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT
  } state_e;
endpackage

// File: rtl/minterm_seq_ram.sv
module minterm_seq_ram #(
  parameter int W     = 42,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wvalue_i,
  input  logic [W-1:0]  wcare_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rvalue_o,
  output logic [W-1:0]  rcare_o
);
  logic [W-1:0] val_mem  [DEPTH];
  logic [W-1:0] care_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      val_mem[waddr_i]  <= wvalue_i;
      care_mem[waddr_i] <= wcare_i;
    end
  end

  assign rvalue_o = val_mem[raddr_i];
  assign rcare_o  = care_mem[raddr_i];
endmodule

// File: rtl/minterm_seq_fold.sv
module minterm_seq_fold #(
  parameter int W = 42
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] care_i,
  input  logic [W-1:0] key_i,
  output logic [W-1:0] value_o,
  output logic [W-1:0] care_o
);
  // key bit 1 flips the expected level; wildcards stay wildcards
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign value_o[b] = care_i[b] & (value_i[b] ^ key_i[b]);
    assign care_o[b]  = care_i[b];
  end
endmodule

// File: rtl/minterm_seq_ctrl.sv
module minterm_seq_ctrl
  import minterm_seq_pkg::*;
#(
  parameter int W         = 42,
  parameter int MAX_TERMS = 64,
  parameter int AW        = 6,
  parameter int CNT_W     = 7,
  parameter int COL_W     = 6,
  parameter int CYC_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [W-1:0]     key_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             issue_o,
  output logic             finish_o,
  output phase_e           phase_o,
  output logic [AW-1:0]    idx_o,
  output logic [W-1:0]     key_o,
  output logic [COL_W-1:0] col_o,
  output logic [CYC_W-1:0] cycles_o
);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_TERMS);

  state_e             state_q;
  phase_e             phase_q;
  logic [AW-1:0]      idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [W-1:0]       key_q;
  logic [COL_W-1:0]   col_q;
  logic [CYC_W-1:0]   cyc_q;
  logic               fin_q;
  logic               last_term;

  assign last_term = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_CLR;
      idx_q   <= '0;
      cnt_q   <= '0;
      key_q   <= '0;
      col_q   <= '0;
      cyc_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q   <= (count_i > MaxCnt) ? MaxCnt : count_i;
            key_q   <= key_i;
            col_q   <= col_i;
            idx_q   <= '0;
            phase_q <= PH_CLR;
            cyc_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          cyc_q   <= cyc_q + CYC_W'(1);
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          cyc_q <= cyc_q + CYC_W'(1);
          if (ack_i) begin
            state_q <= ST_ISSUE;
            unique case (phase_q)
              PH_CLR:   phase_q <= (cnt_q == '0) ? PH_SHIFT : PH_TERM;
              PH_TERM:  phase_q <= PH_ACC;
              PH_ACC: begin
                if (last_term) phase_q <= PH_SHIFT;
                else begin
                  idx_q   <= idx_q + AW'(1);
                  phase_q <= PH_TERM;
                end
              end
              PH_SHIFT: phase_q <= PH_RDCOL;
              PH_RDCOL: phase_q <= PH_XOR;
              PH_XOR:   phase_q <= PH_WRCOL;
              PH_WRCOL: begin
                state_q <= ST_IDLE;
                fin_q   <= 1'b1;
              end
              default:  phase_q <= PH_CLR;
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign issue_o  = state_q == ST_ISSUE;
  assign finish_o = fin_q;
  assign phase_o  = phase_q;
  assign idx_o    = idx_q;
  assign key_o    = key_q;
  assign col_o    = col_q;
  assign cycles_o = cyc_q;
endmodule

// File: rtl/minterm_seq.sv
module minterm_seq
  import minterm_seq_pkg::*;
#(
  parameter int W         = 42,
  parameter int MAX_TERMS = 64,
  parameter int CYC_W     = 16,
  localparam int AW       = $clog2(MAX_TERMS),
  localparam int CNT_W    = $clog2(MAX_TERMS + 1),
  localparam int COL_W    = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [W-1:0]     ld_value_i,
  input  logic [W-1:0]     ld_care_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [W-1:0]     key_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ack_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [1:0]       cmd_reg_o,
  output logic [7:0]       cmd_fn_o,
  output logic [W-1:0]     cmd_value_o,
  output logic [W-1:0]     cmd_care_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             busy_o,
  output logic             finish_o,
  output logic [CYC_W-1:0] cycles_o
);
  phase_e           phase;
  logic [AW-1:0]    idx;
  logic [W-1:0]     key_q;
  logic [COL_W-1:0] col_q;
  logic [W-1:0]     term_val, term_care, pat_val, pat_care, col_hot;
  logic             busy;

  minterm_seq_ctrl #(
    .W(W), .MAX_TERMS(MAX_TERMS), .AW(AW), .CNT_W(CNT_W),
    .COL_W(COL_W), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (count_i),
    .key_i    (key_i),
    .col_i    (col_i),
    .ack_i    (ack_i),
    .busy_o   (busy),
    .issue_o  (cmd_valid_o),
    .finish_o (finish_o),
    .phase_o  (phase),
    .idx_o    (idx),
    .key_o    (key_q),
    .col_o    (col_q),
    .cycles_o (cycles_o)
  );

  // store frozen during a run
  minterm_seq_ram #(.W(W), .DEPTH(MAX_TERMS), .AW(AW)) u_ram (
    .clk_i    (clk_i),
    .we_i     (ld_en_i & ~busy),
    .waddr_i  (ld_addr_i),
    .wvalue_i (ld_value_i),
    .wcare_i  (ld_care_i),
    .raddr_i  (idx),
    .rvalue_o (term_val),
    .rcare_o  (term_care)
  );

  minterm_seq_fold #(.W(W)) u_fold (
    .value_i (term_val),
    .care_i  (term_care),
    .key_i   (key_q),
    .value_o (pat_val),
    .care_o  (pat_care)
  );

  assign col_hot = W'(1) << col_q;
  assign busy_o  = busy;

  always_comb begin
    cmd_op_o    = OP_CALC;
    cmd_reg_o   = REG_R1;
    cmd_fn_o    = FN_ZERO;
    cmd_value_o = '0;
    cmd_care_o  = '0;
    cmd_col_o   = '0;
    unique case (phase)
      PH_CLR: ;
      PH_TERM: begin
        cmd_op_o    = OP_MATCH;
        cmd_reg_o   = REG_R2;
        cmd_value_o = pat_val;
        cmd_care_o  = pat_care;
      end
      PH_ACC:   cmd_fn_o = FN_OR12;
      PH_SHIFT: cmd_op_o = OP_SHIFT;
      PH_RDCOL: begin
        cmd_op_o    = OP_MATCH;
        cmd_reg_o   = REG_R2;
        cmd_value_o = col_hot;
        cmd_care_o  = col_hot;
      end
      PH_XOR:   cmd_fn_o = FN_XOR12;
      PH_WRCOL: begin
        cmd_op_o  = OP_WRCOL;
        cmd_col_o = col_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/minterm_seq_chk.sv
module minterm_seq_chk #(
  parameter int W     = 42,
  parameter int CYC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [7:0]       cmd_fn_o,
  input logic [W-1:0]     cmd_value_o,
  input logic [W-1:0]     cmd_care_o,
  input logic             finish_o,
  input logic [CYC_W-1:0] cycles_o
);
  // R6
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  // R6
  cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);
  // R7
  finish_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> (!busy_o && !cmd_valid_o));
  // R7
  finish_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> !finish_o);
  // R4
  wildcard_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd0) |-> ((cmd_value_o & ~cmd_care_o) == '0));
  // R3
  calc_fn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd1) |->
      (cmd_fn_o == 8'h00 || cmd_fn_o == 8'hEE || cmd_fn_o == 8'h66));
  // R8
  cycles_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cycles_o == '0));
  // R8
  cycles_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (cycles_o == CYC_W'($past(cycles_o) + 1'b1)));
endmodule

bind minterm_seq minterm_seq_chk #(.W(W), .CYC_W(CYC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_fn_o    (cmd_fn_o),
  .cmd_value_o (cmd_value_o),
  .cmd_care_o  (cmd_care_o),
  .finish_o    (finish_o),
  .cycles_o    (cycles_o)
);

// File: tb/minterm_seq_test.sv
module minterm_seq_test;
  localparam int W  = 42;
  localparam int MT = 64;

  typedef logic [101:0] cmd_t; // {op,reg,fn,value,care,col}

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic [5:0]    ld_addr = '0;
  logic [W-1:0]  ld_value = '0, ld_care = '0;
  logic          start = 1'b0;
  logic [6:0]    count = '0;
  logic [W-1:0]  key = '0;
  logic [5:0]    col = '0;
  logic          ack_r = 1'b0, ack_spur = 1'b0;
  logic          cmd_valid;
  logic [1:0]    cmd_op, cmd_reg;
  logic [7:0]    cmd_fn;
  logic [W-1:0]  cmd_value, cmd_care;
  logic [5:0]    cmd_col;
  logic          busy, finish;
  logic [15:0]   cycles;

  int checks = 0;
  int fails = 0;
  cmd_t  exp_q[$];
  string tag_q[$];
  logic [W-1:0] ref_val [MT];
  logic [W-1:0] ref_care[MT];

  always #2 clk = ~clk;

  minterm_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_addr_i(ld_addr),
    .ld_value_i(ld_value), .ld_care_i(ld_care), .start_i(start),
    .count_i(count), .key_i(key), .col_i(col), .ack_i(ack_r | ack_spur),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_fn_o(cmd_fn), .cmd_value_o(cmd_value), .cmd_care_o(cmd_care),
    .cmd_col_o(cmd_col), .busy_o(busy), .finish_o(finish), .cycles_o(cycles)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [1:0] rg, input logic [7:0] fn,
                      input logic [W-1:0] v, input logic [W-1:0] c, input logic [5:0] cl,
                      input string tag);
    exp_q.push_back({op, rg, fn, v, c, cl});
    tag_q.push_back(tag);
  endtask

  // monitor: acts as the array, compares every command against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      ack_r = 1'b0;
      if (rst_n && cmd_valid) begin
        cmd_t got, e;
        string t;
        int cost;
        got = {cmd_op, cmd_reg, cmd_fn, cmd_value, cmd_care, cmd_col};
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected command", 128'(got), 128'(0));
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, "command", 128'(got), 128'(e));
        end
        cost = (cmd_op == 2'd0) ? 4 : 2;
        repeat (cost - 1) @(negedge clk);
        ack_r = 1'b1;
      end
    end
  end

  task automatic load(input int i, input logic [W-1:0] v, input logic [W-1:0] c);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 6'(i); ld_value = v; ld_care = c;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input int n, input logic [W-1:0] k, input int cl,
                     input bit poke, input string ttag);
    logic [W-1:0] hot;
    string ftag;
    int t;
    hot  = W'(1) << cl;
    ftag = (n == 0) ? "R9" : "R5";
    push(2'd1, 2'd1, 8'h00, '0, '0, '0, (n == 0) ? "R9" : "R3");
    for (int i = 0; i < n; i++) begin
      push(2'd0, 2'd2, 8'h00, (ref_val[i] ^ k) & ref_care[i], ref_care[i], '0,
           (poke && i == n - 1) ? "R2/R10" : ttag);
      push(2'd1, 2'd1, 8'hEE, '0, '0, '0, ttag);
    end
    push(2'd2, 2'd1, 8'h00, '0, '0, '0, ftag);
    push(2'd0, 2'd2, 8'h00, hot, hot, '0, ftag);
    push(2'd1, 2'd1, 8'h66, '0, '0, '0, ftag);
    push(2'd3, 2'd1, 8'h00, '0, '0, 6'(cl), ftag);
    @(negedge clk);
    count = 7'(n); key = k; col = 6'(cl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1; count = 7'd1; col = 6'd0;
      ld_en = 1'b1; ld_addr = 6'(n - 1);
      ld_value = ~ref_val[n - 1]; ld_care = ~ref_care[n - 1];
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
    end
    t = 0;
    while (!finish && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(finish == 1'b1, "R7", "finish pulse seen", 128'(finish), 128'(1));
    check(busy == 1'b0, "R7", "idle at finish", 128'(busy), 128'(0));
    check(cycles == 16'(6 * n + 12), "R8", "cycle total", 128'(cycles), 128'(6 * n + 12));
    check(exp_q.size() == 0, "R6", "all commands issued", 128'(exp_q.size()), 128'(0));
    @(negedge clk);
    check(finish == 1'b0, "R7", "finish one cycle", 128'(finish), 128'(0));
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", 128'(busy), 128'(0));
    check(cmd_valid == 1'b0, "R1", "cmd after reset", 128'(cmd_valid), 128'(0));
    check(finish == 1'b0, "R1", "finish after reset", 128'(finish), 128'(0));
    check(cycles == 16'd0, "R1", "cycles after reset", 128'(cycles), 128'(0));
    rst_n = 1'b1;

    for (int i = 0; i < MT; i++) begin
      ref_val[i]  = {$urandom, $urandom} & {W{1'b1}};
      ref_care[i] = {$urandom, $urandom} & {W{1'b1}};
      load(i, ref_val[i], ref_care[i]);
    end

    run(3, '0, 5, 1'b0, "R4");
    run(4, 42'h2AA_5555_F0F0, 41, 1'b1, "R4");
    run(0, 42'h3FF_FFFF_FFFF, 0, 1'b0, "R4");
    run(64, 42'h3FF_FFFF_FFFF, 20, 1'b0, "R4");

    // idle acknowledge pulses must not start anything
    c0 = cycles;
    @(negedge clk); ack_spur = 1'b1;
    repeat (3) @(negedge clk);
    ack_spur = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && cmd_valid == 1'b0, "R6", "idle ack ignored",
          128'({busy, cmd_valid}), 128'(0));
    check(cycles == c0, "R6", "cycles unchanged by idle ack", 128'(cycles), 128'(c0));

    // idle reload is visible to the next run
    ref_val[0]  = 42'h155_AAAA_0F0F;
    ref_care[0] = 42'h0FF_00FF_FFFF;
    load(0, ref_val[0], ref_care[0]);
    run(1, 42'h001_2345_6789, 33, 1'b0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule